// File: doc/BRIEF.md
# De Bruijn Source Route Header Generator

This block sits in the source router of a binary de Bruijn network whose node addresses are D-bit words. A hop from a node shifts its address one place toward the most significant end and appends one new bit at the least significant end. To reach a destination by a shortest path, the source finds the longest overlap between the tail of its own address and the head of the destination address. It then emits only the destination bits that follow that overlap, as the route header.

Each intermediate node forwards on the leading header bit and strips it. A message whose header is empty has arrived. The block is sequential. A start pulse loads both addresses. The search then tries one candidate overlap per clock, from the largest down. A one-cycle done pulse presents the header and its length.

Top module: `debruijn_route_gen`

## Requirements
- R1: After reset, busy, done and self_err are low, and hdr and hdr_len are zero.
- R2: start is accepted only while busy is low. An accepted start raises busy on the next cycle. A start that arrives while busy is high has no effect on the result in progress.
- R3: The overlap k is the largest value in 0..D for which the top k bits of dst (bits D-1 down to D-k) equal the bottom k bits of src (bits k-1 down to 0). k = 0 always qualifies.
- R4: At done, hdr_len equals D-k. hdr holds dst bits D-k-1 down to 0 in bit positions D-1 down to k, and its low k bits are zero.
- R5: Candidates are tried from D downward, one per clock. done is high exactly D-k+1 rising edges after the edge that accepted start, and busy is high until then.
- R6: done is high for one cycle only, and busy is low whenever done is high.
- R7: When src equals dst, k is D. At done, self_err is high, hdr_len is 0 and hdr is 0. In every other case self_err is low at done.
- R8: hdr, hdr_len and self_err change only in a cycle where done is high. They keep their values until the next result.
- R9: Starting from src and shifting in the leading hdr_len bits of hdr, most significant first, reaches dst after exactly hdr_len hops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load src/dst and begin the search |
| src | input | D | Source node address |
| dst | input | D | Destination node address |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: result valid and updated |
| hdr | output | D | Route header, left-justified |
| hdr_len | output | clog2(D+1) | Number of valid header bits |
| self_err | output | 1 | Source equals destination |

## Verification
The bench builds the block with D = 6. At that width every one of the 4096 source/destination pairs can be run within the cycle budget. The exhaustive sweep therefore reaches every overlap length from 0 to 6 and every latency from 1 to 7 cycles. It also covers all self-send cases and pairs whose overlap is short even though a longer partial match exists. On some pairs a second start is issued while the search is still running, to show that it is ignored.

// File: rtl/debruijn_route_gen.sv
module debruijn_route_gen #(
  parameter int D = 8,
  localparam int LW = $clog2(D + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [D-1:0]  src,
  input  logic [D-1:0]  dst,
  output logic          busy,
  output logic          done,
  output logic [D-1:0]  hdr,
  output logic [LW-1:0] hdr_len,
  output logic          self_err
);

  logic [D-1:0]  src_q, dst_q;
  logic [LW-1:0] cand;
  logic [D:0]    fit;

  assign fit[0] = 1'b1;
  for (genvar k = 1; k <= D; k++) begin : g_fit
    assign fit[k] = (dst_q[D-1 -: k] == src_q[k-1:0]);
  end

  wire hit = fit[cand];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      hdr      <= '0;
      hdr_len  <= '0;
      self_err <= 1'b0;
      src_q    <= '0;
      dst_q    <= '0;
      cand     <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          src_q <= src;
          dst_q <= dst;
          cand  <= LW'(D);
        end
      end else if (hit) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        hdr      <= dst_q << cand;
        hdr_len  <= LW'(D) - cand;
        self_err <= (cand == LW'(D));
      end else begin
        cand <= cand - 1'b1;
      end
    end
  end

endmodule

// File: rtl/debruijn_route_chk.sv
module debruijn_route_chk #(
  parameter int D = 8,
  localparam int LW = $clog2(D + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [D-1:0]  hdr,
  input logic [LW-1:0] hdr_len,
  input logic          self_err
);

  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  p_len_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !self_err) |-> (hdr_len != '0 && hdr_len <= LW'(D)));

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_self_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && self_err) |-> (hdr_len == '0 && hdr == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(hdr) && $stable(hdr_len) && $stable(self_err)));

endmodule

bind debruijn_route_gen debruijn_route_chk #(.D(D)) u_chk (.*);

// File: tb/debruijn_route_gen_tb.sv
module debruijn_route_gen_tb;
  localparam int D = 6;
  localparam int LW = $clog2(D + 1);
  localparam int MASK = (1 << D) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [D-1:0] src = '0, dst = '0;
  logic busy, done, self_err;
  logic [D-1:0] hdr;
  logic [LW-1:0] hdr_len;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  debruijn_route_gen #(.D(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src(src), .dst(dst),
    .busy(busy), .done(done), .hdr(hdr), .hdr_len(hdr_len), .self_err(self_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int overlap(input int s, input int d);
    for (int c = D; c > 0; c--)
      if ((d >> (D - c)) == (s & ((1 << c) - 1))) return c;
    return 0;
  endfunction

  task automatic run(input int s, input int d, input bit poke);
    int k, lat, node;
    int eh, el, ee;
    k   = overlap(s, d);
    lat = D - k + 1;
    eh  = (d << k) & MASK;
    el  = D - k;
    ee  = (k == D) ? 1 : 0;
    @(negedge clk);
    src = D'(s); dst = D'(d); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", int'(busy), 1);
    if (poke) begin
      src = D'(~s); dst = D'(s); start = 1'b1;
    end
    for (int j = 1; j <= lat; j++) begin
      @(negedge clk);
      start = 1'b0;
      if (j < lat) begin
        chk(done === 1'b0, "R5 early done", int'(done), 0);
        chk(busy === 1'b1, "R5 busy during search", int'(busy), 1);
      end else begin
        chk(done === 1'b1, "R5 done at latency", int'(done), 1);
        chk(busy === 1'b0, "R6 busy at done", int'(busy), 0);
        chk(int'(hdr_len) == el, "R3 R4 header length", int'(hdr_len), el);
        chk(int'(hdr) == eh, "R4 header bits", int'(hdr), eh);
        chk(int'(self_err) == ee, "R7 self error flag", int'(self_err), ee);
        node = s;
        for (int i = 0; i < int'(hdr_len); i++)
          node = ((node << 1) | int'(hdr[D-1-i])) & MASK;
        chk(node == d, "R9 walk reaches destination", node, d);
      end
    end
    @(negedge clk);
    chk(done === 1'b0, "R6 done single cycle", int'(done), 0);
    chk(int'(hdr) == eh && int'(hdr_len) == el, "R8 result held", int'(hdr), eh);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && self_err === 1'b0, "R1 reset flags",
        int'({busy, done, self_err}), 0);
    chk(hdr === '0 && hdr_len === '0, "R1 reset outputs", int'(hdr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b0, "R1 idle after reset", int'(busy), 0);
    for (int s = 0; s < (1 << D); s++)
      for (int d = 0; d < (1 << D); d++)
        run(s, d, ((s + d) % 5) == 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule